// File: doc/BRIEF.md
# MLT-3 Three-Level Line Encoder and Transition Decoder

This block turns a serial bit stream into a three-level line signal that cycles through positive, zero, negative and zero again. On each clock where the transmit enable is high it takes one data bit. A 0 leaves the line where it is. A 1 moves it one step along the cycle. The encoder keeps two pieces of state: the level it is driving now, and the polarity of the most recent nonzero level it drove. It needs that polarity to decide which way to leave zero.

A companion decoder recovers the bits from a received level stream. On each receive-enabled clock it reports a 1 if the sampled level differs from the previously sampled level, and a 0 if it does not. Encoder and decoder share one clock. Their reset is asserted asynchronously and released synchronously inside the block.

Top module: `mlt3_codec`

## Requirements
- R1: After reset the line is at zero (2'b00), the remembered last nonzero polarity is negative, so the first 1 drives the line positive, and the decoder output is 0.
- R2: An enabled 0 bit leaves the line level unchanged.
- R3: An enabled 1 bit while the line is positive (2'b01) or negative (2'b11) drives the line to zero (2'b00).
- R4: An enabled 1 bit while the line is zero drives it to the polarity opposite the last nonzero level.
- R5: A continuous run of enabled 1 bits from reset gives the repeating sequence positive, zero, negative, zero, with a period of four bits.
- R6: When the transmit enable is low, the line level and the remembered polarity do not change, whatever the data bit is.
- R7: The level output only ever takes the codes 2'b00 (zero), 2'b01 (positive) and 2'b11 (negative). It never takes 2'b10, and it never moves directly between positive and negative.
- R8: On each receive-enabled clock the decoder output becomes 1 if the sampled level differs from the last sampled level and 0 otherwise. The last sampled level starts at zero after reset.
- R9: When the receive enable is low, the decoder output and its remembered level do not change.
- R10: When the encoder output is fed back into the decoder one bit at a time, the decoder reproduces the transmitted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| tx_en | input | 1 | Accept `tx_bit` on this clock |
| tx_bit | input | 1 | Serial data bit to encode |
| tx_level | output | 2 | Line level: 00 zero, 01 positive, 11 negative |
| rx_en | input | 1 | Sample `rx_level` on this clock |
| rx_level | input | 2 | Received line level, same coding as `tx_level` |
| rx_bit | output | 1 | Decoded bit, held between enabled samples |

## Verification
The bench targets the polarity memory in several ways:
- A 1 arriving at zero after a run of 0 bits, and a run of eight ones, are both checked. An encoder that chose the polarity from the current level, or reset the memory to positive, would step negative first or repeat the same polarity.
- Pulses of 1 with the enable held low are checked. A design that ignored the enable would advance the cycle.

The decoder is driven directly with repeated and changing levels, and with its enable low. A design that compared against the wrong previous sample, or updated while disabled, would report spurious ones. A mixed pattern is then looped back through the decoder to confirm the two halves agree.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } level_t;

  localparam int unsigned LEVEL_W = 2;

  function automatic logic is_nonzero(input logic [LEVEL_W-1:0] lvl);
    return lvl != LVL_ZERO;
  endfunction

endpackage

// File: rtl/mlt3_rst_sync.sv
module mlt3_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/mlt3_encoder.sv
module mlt3_encoder
  import mlt3_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                bit_in,
  output logic [LEVEL_W-1:0]  level_out
);

  level_t level_q, level_d;
  logic   last_pos_q, last_pos_d;

  // next-state
  always_comb begin
    level_d    = level_q;
    last_pos_d = last_pos_q;
    if (bit_en && bit_in) begin
      if (is_nonzero(level_q)) begin
        level_d = LVL_ZERO;
      end else begin
        level_d    = last_pos_q ? LVL_NEG : LVL_POS;
        last_pos_d = ~last_pos_q;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q    <= LVL_ZERO;
      last_pos_q <= 1'b0;
    end else if (bit_en) begin
      level_q    <= level_d;
      last_pos_q <= last_pos_d;
    end
  end

  assign level_out = level_q;

endmodule

// File: rtl/mlt3_decoder.sv
module mlt3_decoder
  import mlt3_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_en,
  input  logic [LEVEL_W-1:0]  level_in,
  output logic                bit_out
);

  logic [LEVEL_W-1:0] prev_q, prev_d;
  logic               bit_q, bit_d;

  // next-state
  always_comb begin
    prev_d = prev_q;
    bit_d  = bit_q;
    if (smp_en) begin
      bit_d  = (level_in != prev_q);
      prev_d = level_in;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= LVL_ZERO;
      bit_q  <= 1'b0;
    end else if (smp_en) begin
      prev_q <= prev_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_out = bit_q;

endmodule

// File: rtl/mlt3_codec.sv
module mlt3_codec
  import mlt3_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_bit,
  output logic [1:0] tx_level,
  input  logic       rx_en,
  input  logic [1:0] rx_level,
  output logic       rx_bit
);

  logic rst_sync_n;

  mlt3_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mlt3_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bit_en    (tx_en),
    .bit_in    (tx_bit),
    .level_out (tx_level)
  );

  mlt3_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .smp_en   (rx_en),
    .level_in (rx_level),
    .bit_out  (rx_bit)
  );

endmodule

// File: rtl/mlt3_codec_sva.sv
module mlt3_codec_sva (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       tx_en,
  input logic       tx_bit,
  input logic [1:0] tx_level,
  input logic       rx_en,
  input logic [1:0] rx_level,
  input logic       rx_bit
);

  // Checker-side record of the last sampled receive level.
  logic [1:0] seen_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  seen_q <= 2'b00;
    else if (rx_en)   seen_q <= rx_level;
  end

  a_r2_zero_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_en && !tx_bit) |=> $stable(tx_level));

  a_r3_one_returns_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_en && tx_bit && tx_level != 2'b00) |=> (tx_level == 2'b00));

  a_r4_one_leaves_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_en && tx_bit && tx_level == 2'b00) |=> (tx_level != 2'b00));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_en |=> $stable(tx_level));

  a_r7_legal_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_level != 2'b10);

  a_r7_no_swing: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_level[0] |=> (tx_level == $past(tx_level) || tx_level == 2'b00));

  a_r8_change_detect: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_en |=> (rx_bit == ($past(rx_level) != $past(seen_q))));

  a_r9_rx_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_en |=> $stable(rx_bit));

endmodule

bind mlt3_codec mlt3_codec_sva u_sva (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tx_en      (tx_en),
  .tx_bit     (tx_bit),
  .tx_level   (tx_level),
  .rx_en      (rx_en),
  .rx_level   (rx_level),
  .rx_bit     (rx_bit)
);

// File: tb/mlt3_codec_bench.sv
`timescale 1ns/1ps
module mlt3_codec_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, tx_bit, rx_en, rx_bit;
  logic [1:0] tx_level, rx_level;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model of the encoder
  logic [1:0] m_lvl;
  logic       m_lastpos;

  always #2 clk = ~clk;

  mlt3_codec u_mlt3_codec (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .tx_bit(tx_bit), .tx_level(tx_level),
    .rx_en(rx_en), .rx_level(rx_level), .rx_bit(rx_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_en = 0; tx_bit = 0; rx_en = 0; rx_level = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_lvl = 2'b00; m_lastpos = 1'b0;
  endtask

  // Encode one bit; sampled one cycle later, away from the edge.
  task automatic send(input logic en, input logic b);
    @(negedge clk);
    tx_en = en; tx_bit = b; rx_en = 0;
    @(negedge clk);
    tx_en = 0;
    if (en && b) begin
      if (m_lvl != 2'b00) m_lvl = 2'b00;
      else begin m_lvl = m_lastpos ? 2'b11 : 2'b01; m_lastpos = ~m_lastpos; end
    end
  endtask

  task automatic feed(input logic en, input logic [1:0] lvl);
    @(negedge clk);
    rx_en = en; rx_level = lvl;
    @(negedge clk);
    rx_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset level", tx_level, 0);
    check("R1 reset rx_bit", rx_bit, 0);
    send(1, 1);
    check("R1 first one positive", tx_level, 1);
  endtask

  task automatic t_zeros_hold();
    do_reset();
    send(1, 1);
    for (int i = 0; i < 3; i++) begin
      send(1, 0);
      check("R2 zero holds positive", tx_level, 1);
    end
    send(1, 1);
    check("R3 positive to zero", tx_level, 0);
    send(1, 0); send(1, 0);
    check("R2 zero holds zero", tx_level, 0);
    send(1, 1);
    check("R4 zero to negative after positive", tx_level, 3);
    send(1, 1);
    check("R3 negative to zero", tx_level, 0);
    send(1, 0);
    send(1, 1);
    check("R4 zero to positive after negative", tx_level, 1);
  endtask

  task automatic t_run_ones();
    int exp_seq[4] = '{1, 0, 3, 0};
    do_reset();
    for (int i = 0; i < 8; i++) begin
      send(1, 1);
      check($sformatf("R5 run step %0d", i), tx_level, exp_seq[i % 4]);
    end
  endtask

  task automatic t_enable_low();
    do_reset();
    send(1, 1);
    for (int i = 0; i < 4; i++) begin
      send(0, 1);
      check("R6 disabled one ignored", tx_level, 1);
    end
    send(1, 1);
    check("R6 cycle resumes at zero", tx_level, 0);
    send(0, 1);
    send(1, 1);
    check("R6 polarity memory kept", tx_level, 3);
  endtask

  task automatic t_decoder_direct();
    do_reset();
    feed(1, 2'b00); check("R8 same as reset level", rx_bit, 0);
    feed(1, 2'b01); check("R8 zero to positive", rx_bit, 1);
    feed(1, 2'b01); check("R8 repeat positive", rx_bit, 0);
    feed(1, 2'b11); check("R8 positive to negative", rx_bit, 1);
    feed(1, 2'b00); check("R8 negative to zero", rx_bit, 1);
  endtask

  task automatic t_rx_hold();
    do_reset();
    feed(1, 2'b01);
    check("R9 setup", rx_bit, 1);
    feed(0, 2'b11);
    check("R9 disabled sample ignored", rx_bit, 1);
    feed(1, 2'b01);
    check("R9 previous level unchanged", rx_bit, 0);
  endtask

  task automatic t_loopback();
    logic [15:0] pat = 16'b1011_0011_1110_0101;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      send(1, pat[i]);
      check("R7 level matches model", tx_level, m_lvl);
      if (tx_level == 2'b10) check("R7 illegal code", tx_level, 0);
      feed(1, tx_level);
      check($sformatf("R10 loopback bit %0d", i), rx_bit, pat[i]);
    end
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 0; tx_bit = 0; rx_en = 0; rx_level = 2'b00;
    m_lvl = 2'b00; m_lastpos = 1'b0;
    t_reset();
    t_zeros_hold();
    t_run_ones();
    t_enable_low();
    t_decoder_direct();
    t_rx_hold();
    t_loopback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule